// File: doc/BRIEF.md
# Capture/Compare/PWM Counter-Timer

This block is a 16-bit up-counter with two compare registers, two capture inputs and two compare output pins. The counter advances either on the system clock divided by a power of two, or on rising edges of a shared external count input that the block synchronises itself. Each capture input latches the running count on a programmable edge. Each compare register, on a match, drives its output pin to a programmed level. In PWM mode the two compare registers act together on output 0: one sets the period, the other sets the duty.

Software reaches the block through a synchronous write port and a combinational read port addressed by a 3-bit register index. Event flags are sticky and cleared by writing ones. A single interrupt line combines the flags whose enables are set.

Register map (index: content): 0 control, 1 interrupt enables, 2 event flags, 3 compare 0, 4 compare 1, 5 capture A (read-only), 6 capture B (read-only), 7 counter (writing loads it). Control fields: bit 0 run, bit 1 PWM mode, bit 2 count external edges, bits 5:3 prescale exponent n, bits 7:6 capture A edge, bits 9:8 capture B edge, bit 10 compare 0 output level, bit 11 compare 1 output level. Edge codes: 00 none, 01 rising, 10 falling, 11 both. Flag and enable bits: 0 capture A, 1 capture B, 2 compare 0 match, 3 compare 1 match, 4 overflow.

Top module: `cctimer`

## Requirements
- R1: After reset every register reads 0, both compare outputs are low and the interrupt is low.
- R2: With run set and the internal source selected, the counter advances once every 2^n clock cycles (n from control bits 5:3, 0 to 7), the first step coming 2^n cycles after run is written; with run clear it holds its value.
- R3: With control bit 2 set, the counter advances once per rising edge of ext_clk, after a two-flop synchroniser, and not on the system clock.
- R4: Outside PWM mode, a count step taken while the counter equals compare register k drives cmp_out[k] to control bit 10+k and sets flag 2+k.
- R5: In PWM mode, a step at a match with compare 0 clears the counter to 0 and sets cmp_out[0]; a step at a match with compare 1 clears cmp_out[0]; so cmp_out[0] is high exactly while the counter is at most compare 1, and the counter never exceeds compare 0.
- R6: A selected edge on a capture input (codes 01 rising, 10 falling, 11 both) copies the counter into that input's capture register and sets its flag (bit 0 for A, bit 1 for B); unselected edges change neither.
- R7: Flags stay set until a write to index 2 with a 1 in their position; zeros written leave them unchanged.
- R8: A step taken at count 0xFFFF wraps the counter to 0 and sets flag 4.
- R9: irq is high exactly when some flag is set together with its enable bit.
- R10: A write to index 7 loads the counter, taking precedence over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| ext_clk | input | 1 | Shared external count input |
| cap_a | input | 1 | Capture input A |
| cap_b | input | 1 | Capture input B |
| cmp_out | output | 2 | Compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
The properties take it that ext_clk, cap_a and cap_b stay at each level for at least two system clocks, so the synchronisers see every edge, and that software only loads the counter through index 7. The stimulus holds every external pulse for three cycles or more, and checks the PWM bound only across windows where compare 0 and the counter are left untouched. The PWM run keeps compare 1 below compare 0, so each period has both a high and a low phase.

// File: rtl/cctimer.sv
module cctimer #(
  parameter int W   = 16,
  parameter int PSW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ext_clk,
  input  logic         cap_a,
  input  logic         cap_b,
  output logic [1:0]   cmp_out,
  output logic         irq
);
  localparam int PW = (1 << PSW) - 1;
  localparam int CW = PSW + 9;

  logic [CW-1:0] ctrl;
  logic [4:0]    ien, stat;
  logic [W-1:0]  cmp0, cmp1, capa, capb, cnt;
  logic [PW-1:0] pre;
  logic [2:0]    xs, as, bs;

  wire           run  = ctrl[0];
  wire           pwm  = ctrl[1];
  wire           ext  = ctrl[2];
  wire [PSW-1:0] psc  = ctrl[3 +: PSW];
  wire [1:0]     ea   = ctrl[PSW+3 +: 2];
  wire [1:0]     eb   = ctrl[PSW+5 +: 2];
  wire [1:0]     lvl  = ctrl[PSW+7 +: 2];

  wire [PW-1:0] mask = PW'((1 << psc) - 1);
  wire tick  = run & (ext ? (xs[1] & ~xs[2]) : ((pre & mask) == mask));
  wire hit0  = tick && (cnt == cmp0);
  wire hit1  = tick && (cnt == cmp1);
  wire wrap  = pwm && hit0;
  wire ovf   = tick && !wrap && (cnt == {W{1'b1}});
  wire ha    = (ea[0] & as[1] & ~as[2]) | (ea[1] & ~as[1] & as[2]);
  wire hb    = (eb[0] & bs[1] & ~bs[2]) | (eb[1] & ~bs[1] & bs[2]);
  wire wsel  = wr_en && (addr == 3'd2);
  wire [4:0] clr = wsel ? wdata[4:0] : 5'd0;

  assign irq = |(stat & ien);

  always_comb begin
    case (addr)
      3'd0: rdata = W'(ctrl);
      3'd1: rdata = W'(ien);
      3'd2: rdata = W'(stat);
      3'd3: rdata = cmp0;
      3'd4: rdata = cmp1;
      3'd5: rdata = capa;
      3'd6: rdata = capb;
      default: rdata = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; ien <= '0; cmp0 <= '0; cmp1 <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: ctrl <= wdata[CW-1:0];
        3'd1: ien  <= wdata[4:0];
        3'd3: cmp0 <= wdata;
        3'd4: cmp1 <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs <= '0; as <= '0; bs <= '0; pre <= '0;
    end else begin
      xs  <= {xs[1:0], ext_clk};
      as  <= {as[1:0], cap_a};
      bs  <= {bs[1:0], cap_b};
      pre <= run ? pre + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (wr_en && addr == 3'd7) cnt <= wdata;
    else if (tick)                cnt <= wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capa <= '0; capb <= '0; stat <= '0;
    end else begin
      if (ha) capa <= cnt;
      if (hb) capb <= cnt;
      stat <= (stat & ~clr) | {ovf, hit1, hit0, hb, ha};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= '0;
    else if (pwm) begin
      if (hit0)      cmp_out[0] <= 1'b1;
      else if (hit1) cmp_out[0] <= 1'b0;
    end else begin
      if (hit0) cmp_out[0] <= lvl[0];
      if (hit1) cmp_out[1] <= lvl[1];
    end
  end
endmodule

// File: rtl/cctimer_chk.sv
module cctimer_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp0,
  input logic         pwm,
  input logic         run,
  input logic         lvl0,
  input logic         hit0,
  input logic [4:0]   stat,
  input logic [4:0]   ien,
  input logic         irq,
  input logic [1:0]   cmp_out
);
  wire cnt_wr = wr_en && (addr == 3'd7);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(cnt_wr)) |-> $stable(cnt)); // R2
  AST_CMP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pwm && hit0) |-> cmp_out[0] == $past(lvl0)); // R4
  AST_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwm && hit0) |-> (cmp_out[0] && cnt == '0)); // R5
  AST_PWM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && $past(pwm) && $stable(cmp0) && $past(cnt <= cmp0) && !$past(cnt_wr)) |-> cnt <= cmp0); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~stat) != 5'd0) |-> $past(wr_en && addr == 3'd2)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat != $past(stat) || ien != $past(ien))); // R9
endmodule

bind cctimer cctimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .cnt(cnt), .cmp0(cmp0),
  .pwm(pwm), .run(run), .lvl0(lvl[0]), .hit0(hit0), .stat(stat), .ien(ien),
  .irq(irq), .cmp_out(cmp_out)
);

// File: tb/cctimer_bench.sv
module cctimer_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_clk = 0, cap_a = 0, cap_b = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0] cmp_out;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  cctimer u_cctimer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .cap_a(cap_a), .cap_b(cap_b), .cmp_out(cmp_out), .irq(irq));

  always #5 clk = ~clk;

  // prescale exponent, cycles run, expected count
  localparam int VEC [5][3] = '{'{0, 10, 10}, '{1, 10, 5}, '{2, 13, 3}, '{3, 20, 2}, '{7, 300, 2}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic run_for(input logic [15:0] ctl, input int n);
    wr(3'd0, ctl);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, ctl & 16'hFFFE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); chk("R1 register reset", v, 0);
    end
    chk("R1 outputs reset", {cmp_out, irq}, 0);

    for (int i = 0; i < 5; i++) begin
      wr(3'd7, 0);
      run_for(16'(1 | (VEC[i][0] << 3)), VEC[i][1]);
      rd(3'd7, v); chk("R2 prescaled count", v, VEC[i][2]);
    end
    repeat (5) @(negedge clk);
    rd(3'd7, v); chk("R2 hold when stopped", v, 2);

    wr(3'd3, 5); wr(3'd4, 100); wr(3'd7, 0); wr(3'd2, 16'h1F);
    run_for(16'h0401, 10);
    chk("R4 compare drives high", cmp_out, 2'b01);
    rd(3'd2, v); chk("R4 compare flag", v, 16'h04);
    wr(3'd7, 0);
    run_for(16'h0001, 10);
    chk("R4 compare drives low", cmp_out, 2'b00);

    wr(3'd3, 9); wr(3'd4, 3); wr(3'd7, 0);
    wr(3'd0, 16'h0003);
    repeat (12) @(negedge clk);
    for (int k = 0; k < 30; k++) begin
      rd(3'd7, v);
      chk("R5 counter within period", v <= 9, 1);
      chk("R5 pwm level", cmp_out[0], v <= 3);
      @(negedge clk);
    end
    wr(3'd0, 16'h0002);

    wr(3'd7, 0);
    wr(3'd0, 16'h0005);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1; repeat (3) @(negedge clk);
      ext_clk = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h0004);
    rd(3'd7, v); chk("R3 external edges counted", v, 5);

    wr(3'd0, 16'h0240); wr(3'd7, 16'h1234); wr(3'd2, 16'h1F);
    cap_a = 1; repeat (5) @(negedge clk);
    rd(3'd5, v); chk("R6 capture A rising", v, 16'h1234);
    rd(3'd2, v); chk("R6 capture A flag", v, 16'h01);
    cap_b = 1; repeat (5) @(negedge clk);
    rd(3'd6, v); chk("R6 capture B ignores rising", v, 0);
    rd(3'd2, v); chk("R6 capture B flag clear", v, 16'h01);
    wr(3'd7, 16'h0042);
    cap_b = 0; repeat (5) @(negedge clk);
    rd(3'd6, v); chk("R6 capture B falling", v, 16'h0042);
    wr(3'd0, 16'h02C0); wr(3'd7, 16'h0077);
    cap_a = 0; repeat (5) @(negedge clk);
    rd(3'd5, v); chk("R6 capture A both edges", v, 16'h0077);

    rd(3'd2, v); chk("R7 flags sticky", v, 16'h03);
    wr(3'd2, 16'h0001);
    rd(3'd2, v); chk("R7 write one clears", v, 16'h02);

    wr(3'd1, 16'h0002); #1;
    chk("R9 enabled flag raises irq", irq, 1);
    wr(3'd1, 16'h0001); #1;
    chk("R9 disabled flag keeps irq low", irq, 0);

    wr(3'd2, 16'h1F); wr(3'd7, 16'hFFFE);
    run_for(16'h0001, 3);
    rd(3'd7, v); chk("R8 wrap to low count", v, 1);
    rd(3'd2, v); chk("R8 overflow flag", v, 16'h10);

    wr(3'd0, 16'h0001);
    repeat (3) @(negedge clk);
    wr(3'd7, 16'h0100);
    wr(3'd0, 16'h0000);
    rd(3'd7, v); chk("R10 load while running", v, 16'h0101);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule